// File: doc/BRIEF.md
# Frame octets to converter samples

This block sits in the receive transport layer of a serial converter link. Once per frame clock it takes the octets of one frame and a status word for each lane. It cuts the frame into converter samples, returns each control bit to the sample it belongs to, and drops the tail bits. All results come out of a register stage, so they appear one frame clock after the frame is applied.

The frame is read most significant bit first. The first field of the frame is the sample data, ordered by converter and then by sample within a converter. Control words follow the sample data. Any bits left over after the control words are tail bits and are never used. All field positions are derived from the parameters. With more than one lane, the lane buses are read as one long frame with lane 0 at the top, and the status words are merged by OR.

Top module: `frame_demap`

## Requirements
- R1: While rst_ni is low, smp_data_o, smp_ctrl_o and frm_stat_o are all zero. The reset acts asynchronously.
- R2: Sample slot j = c*SMP_PER_CONV + s (converter c, sample s) is taken from the FRAME bits [FRM_W-1-j*SMP_W -: SMP_W], with FRM_W = LANES*OCTS*8. It appears on smp_data_o[j*SMP_W +: SMP_W]. With the default parameters, converter 0 comes from frame bits 23:20 and goes to output bits 3:0.
- R3: The control region begins at the frame bit just below the sample data. Control bit k of slot j is frame bit (CTRL_TOP - j*CTRL_PER_SMP - k), where CTRL_TOP = FRM_W-1-NUM_CONV*SMP_PER_CONV*SMP_W. It appears on smp_ctrl_o[j*CTRL_PER_SMP + k]. With the default parameters, the control bit of converter c is frame bit 7-c.
- R4: The frame bits below the control region (bits 3:0 with the default parameters) have no effect on any output.
- R5: Every output shows the inputs that were present at the previous rising clock edge. An input change does not show until the next edge.
- R6: frm_stat_o is the bitwise OR of the STAT_W-bit status words of all lanes, with the same one-cycle latency. For one lane it equals the lane status.
- R7: With the default parameters (4 converters, 1 sample, 1 lane, 3 octets, 4-bit samples, 1 control bit, 1 control word), the results are as follows. Frame 0xBE14A0 gives samples 1011, 1110, 0001, 0100 and control bits 1, 0, 1, 0. Frame 0x1111F0 gives 0001 with control bit 1 on every converter. Frame 0xEEEE00 gives 1110 with control bit 0 on every converter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Frame clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_data_i | input | LANES*OCTS*8 | Frame octets of all lanes, lane 0 and most significant bit first |
| lane_stat_i | input | LANES*STAT_W | Status word of each lane, lane 0 in the low bits |
| smp_data_o | output | NUM_CONV*SMP_PER_CONV*SMP_W | Samples, one slot per converter and sample |
| smp_ctrl_o | output | NUM_CONV*SMP_PER_CONV*CTRL_PER_SMP | Control bits returned to their slots |
| frm_stat_o | output | STAT_W | Merged frame status |

## Verification
Two things are hardest to show at the ports. The first is that the tail bits are really dropped. The second is that each control bit goes to its own converter rather than to a neighbour, because the reference frames set either all control bits or alternate ones. The bench holds the sample and control fields fixed and changes only the tail across several frames, checking that the outputs keep their values. It then walks a single set bit through every frame position, so that each position is shown to reach exactly one output bit, or none for a tail position.

// File: rtl/demap_pkg.sv
package demap_pkg;
  localparam int unsigned OCT_W = 8;

  // bits per control word, rounded up when the words do not divide evenly
  function automatic int unsigned ctrl_word_w(input int unsigned bits, input int unsigned words);
    return (bits + words - 1) / words;
  endfunction
endpackage

// File: rtl/demap_sample_slicer.sv
module demap_sample_slicer #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned SMP_W = 4,
  localparam int unsigned REG_W = SLOTS * SMP_W
) (
  input  logic [REG_W-1:0] region_i,
  output logic [REG_W-1:0] smp_o
);
  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    // slot 0 sits in the most significant field
    assign smp_o[j*SMP_W +: SMP_W] = region_i[REG_W-1-j*SMP_W -: SMP_W];
  end
endmodule

// File: rtl/demap_ctrl_router.sv
module demap_ctrl_router #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned CS     = 1,
  parameter int unsigned REG_W  = 4,
  localparam int unsigned USE_W = SLOTS * CS,
  localparam int unsigned PAD_W = REG_W - USE_W
) (
  input  logic [REG_W-1:0] region_i,
  output logic [USE_W-1:0] ctrl_o
);
  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    for (genvar k = 0; k < CS; k++) begin : g_bit
      assign ctrl_o[j*CS + k] = region_i[REG_W-1-j*CS-k];
    end
  end

  if (PAD_W > 0) begin : g_pad
    logic unused_pad;
    assign unused_pad = ^region_i[PAD_W-1:0];
  end
endmodule

// File: rtl/demap_stat_merge.sv
module demap_stat_merge #(
  parameter int unsigned LANES  = 1,
  parameter int unsigned STAT_W = 8
) (
  input  logic [LANES*STAT_W-1:0] stat_i,
  output logic [STAT_W-1:0]       stat_o
);
  logic [STAT_W-1:0] acc [LANES+1];
  assign acc[0] = '0;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign acc[l+1] = acc[l] | stat_i[l*STAT_W +: STAT_W];
  end
  assign stat_o = acc[LANES];
endmodule

// File: rtl/frame_demap.sv
module frame_demap #(
  parameter int unsigned NUM_CONV     = 4,
  parameter int unsigned SMP_PER_CONV = 1,
  parameter int unsigned LANES        = 1,
  parameter int unsigned OCTS         = 3,
  parameter int unsigned SMP_W        = 4,
  parameter int unsigned CTRL_PER_SMP = 1,
  parameter int unsigned CTRL_WORDS   = 1,
  parameter int unsigned STAT_W       = 8,
  localparam int unsigned FRM_W  = LANES * OCTS * demap_pkg::OCT_W,
  localparam int unsigned SLOTS  = NUM_CONV * SMP_PER_CONV,
  localparam int unsigned SMP_TOT = SLOTS * SMP_W,
  localparam int unsigned CBITS  = SLOTS * CTRL_PER_SMP,
  localparam int unsigned CW_W   = demap_pkg::ctrl_word_w(CBITS, CTRL_WORDS),
  localparam int unsigned CREG_W = CW_W * CTRL_WORDS,
  localparam int unsigned TAIL_W = FRM_W - SMP_TOT - CREG_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [FRM_W-1:0]          lane_data_i,
  input  logic [LANES*STAT_W-1:0]   lane_stat_i,
  output logic [SMP_TOT-1:0]        smp_data_o,
  output logic [CBITS-1:0]          smp_ctrl_o,
  output logic [STAT_W-1:0]         frm_stat_o
);
  initial assert (FRM_W >= SMP_TOT + CREG_W)
    else $error("frame too narrow for samples and control words");

  logic [SMP_TOT-1:0] smp_region, smp_nxt;
  logic [CREG_W-1:0]  ctrl_region;
  logic [CBITS-1:0]   ctrl_nxt;
  logic [STAT_W-1:0]  stat_nxt;

  assign smp_region  = lane_data_i[FRM_W-1 -: SMP_TOT];
  assign ctrl_region = lane_data_i[FRM_W-1-SMP_TOT -: CREG_W];

  if (TAIL_W > 0) begin : g_tail
    logic unused_tail;
    assign unused_tail = ^lane_data_i[TAIL_W-1:0];
  end

  demap_sample_slicer #(.SLOTS(SLOTS), .SMP_W(SMP_W)) i_slicer (
    .region_i (smp_region),
    .smp_o    (smp_nxt)
  );

  demap_ctrl_router #(.SLOTS(SLOTS), .CS(CTRL_PER_SMP), .REG_W(CREG_W)) i_router (
    .region_i (ctrl_region),
    .ctrl_o   (ctrl_nxt)
  );

  demap_stat_merge #(.LANES(LANES), .STAT_W(STAT_W)) i_merge (
    .stat_i (lane_stat_i),
    .stat_o (stat_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_data_o <= '0;
      smp_ctrl_o <= '0;
      frm_stat_o <= '0;
    end else begin
      smp_data_o <= smp_nxt;
      smp_ctrl_o <= ctrl_nxt;
      frm_stat_o <= stat_nxt;
    end
  end

  // R2/R5: slot 0 mirrors the top frame field of the previous edge
  p_slot0_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> smp_data_o[SMP_W-1:0] == $past(lane_data_i[FRM_W-1 -: SMP_W]));

  // R3: first control bit comes from just below the sample data
  p_ctrl0_lat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> smp_ctrl_o[0] == $past(lane_data_i[FRM_W-1-SMP_TOT]));

  // R6: every status bit of lane 0 reaches the merged output
  p_stat_cover_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ($past(lane_stat_i[STAT_W-1:0]) & ~frm_stat_o) == '0);

  // R4: frames equal outside the tail leave the outputs unchanged
  p_tail_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(rst_ni, 2) &&
     $past(lane_data_i[FRM_W-1 -: SMP_TOT+CREG_W]) == $past(lane_data_i[FRM_W-1 -: SMP_TOT+CREG_W], 2))
    |-> ($stable(smp_data_o) && $stable(smp_ctrl_o)));
endmodule

// File: tb/test_frame_demap.sv
module test_frame_demap;
  localparam int FW = 24;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [23:0] lane_data_i = '0;
  logic [7:0]  lane_stat_i = '0;
  logic [15:0] smp_data_o;
  logic [3:0]  smp_ctrl_o;
  logic [7:0]  frm_stat_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  frame_demap i_frame_demap (
    .clk_i, .rst_ni, .lane_data_i, .lane_stat_i,
    .smp_data_o, .smp_ctrl_o, .frm_stat_o
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_data(input logic [23:0] f);
    logic [15:0] d;
    for (int j = 0; j < 4; j++) d[j*4 +: 4] = f[23-4*j -: 4];
    return d;
  endfunction

  function automatic logic [3:0] exp_ctrl(input logic [23:0] f);
    logic [3:0] c;
    for (int j = 0; j < 4; j++) c[j] = f[7-j];
    return c;
  endfunction

  // apply at a falling edge, look one clock later
  task automatic apply(input logic [23:0] f, input logic [7:0] s);
    @(negedge clk_i);
    lane_data_i = f;
    lane_stat_i = s;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    #1 rst_ni = 1'b0;
    lane_data_i = 24'hFFFFFF;
    lane_stat_i = 8'hFF;
    repeat (2) @(negedge clk_i);
    check("R1 data", 32'(smp_data_o), 0);
    check("R1 ctrl", 32'(smp_ctrl_o), 0);
    check("R1 stat", 32'(frm_stat_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_vectors();
    apply(24'hBE14A0, 8'h01);
    check("R7 data A", 32'(smp_data_o), 32'h41EB);
    check("R7 ctrl A", 32'(smp_ctrl_o), 32'h5);
    check("R6 stat A", 32'(frm_stat_o), 32'h01);
    apply(24'h1111F0, 8'h01);
    check("R7 data B", 32'(smp_data_o), 32'h1111);
    check("R7 ctrl B", 32'(smp_ctrl_o), 32'hF);
    apply(24'hEEEE00, 8'h01);
    check("R7 data C", 32'(smp_data_o), 32'hEEEE);
    check("R7 ctrl C", 32'(smp_ctrl_o), 32'h0);
  endtask

  task automatic t_latency();
    @(negedge clk_i);
    lane_data_i = 24'h5A3CC0;
    lane_stat_i = 8'h80;
    #1;
    check("R5 hold data", 32'(smp_data_o), 32'hEEEE);
    check("R5 hold stat", 32'(frm_stat_o), 32'h01);
    @(negedge clk_i);
    check("R5 data", 32'(smp_data_o), 32'(exp_data(24'h5A3CC0)));
    check("R5 ctrl", 32'(smp_ctrl_o), 32'(exp_ctrl(24'h5A3CC0)));
    check("R5 stat", 32'(frm_stat_o), 32'h80);
  endtask

  task automatic t_tail();
    for (int t = 0; t < 16; t++) begin
      apply({20'h9C6A5, 4'(t)}, 8'h00);
      check("R4 data", 32'(smp_data_o), 32'(exp_data(24'h9C6A50)));
      check("R4 ctrl", 32'(smp_ctrl_o), 32'(exp_ctrl(24'h9C6A50)));
    end
  endtask

  task automatic t_walk();
    for (int b = 0; b < FW; b++) begin
      logic [23:0] f;
      f = 24'(1) << b;
      apply(f, 8'(1) << (b % 8));
      check("R2 walk", 32'(smp_data_o), 32'(exp_data(f)));
      check("R3 walk", 32'(smp_ctrl_o), 32'(exp_ctrl(f)));
      check("R6 walk", 32'(frm_stat_o), 32'(8'(1) << (b % 8)));
    end
  endtask

  task automatic t_reset_mid();
    apply(24'h123456, 8'hA5);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 mid data", 32'(smp_data_o), 0);
    check("R1 mid ctrl", 32'(smp_ctrl_o), 0);
    check("R1 mid stat", 32'(frm_stat_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(24'h123456, 8'hA5);
    check("R2 after reset", 32'(smp_data_o), 32'h4321);
    check("R3 after reset", 32'(smp_ctrl_o), 32'(exp_ctrl(24'h123456)));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000", cyc);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_vectors();
    t_latency();
    t_tail();
    t_walk();
    t_reset_mid();
    finish_run();
  end
endmodule